// File: doc/BRIEF.md
# Flash Page Wipe Engine

This engine clears a contiguous range of flash pages, starting at page zero and stopping before a programmable end page. Every page is first erased. Each bus word of the page is then programmed with caller-supplied filler in a burst of several beats, and the same word is read straight back over the same burst length. Every returned beat is compared against the filler beat with the same index. The engine completes one word, both its program and its read-back, before it moves on to the next word.

The engine acts as the master of a simple flash operation port. It issues a start pulse together with an operation code, a page/word address and a beat count. It then moves write beats on a valid/ready handshake, or takes read beats on valid, and waits for the flash to signal completion. A halt input parks the engine for good at its next decision point. A wipe-done pulse marks a finished range. Any read-back mismatch leaves a sticky verify error.

Top module: `flash_wipe_engine`

## Requirements
- R1: After reset the engine is idle: opStart, wValid, rReady, wipeDone, verifyErr and fsmErr are all low.
- R2: A wipeReq in idle wipes pages 0 through endPage-1, each erased exactly once with opType 2'b10 and opAddr = {page, word 0}. Pages at or above endPage are never written.
- R3: When the page counter reaches endPage the engine gives a single-cycle wipeDone pulse and returns to idle, where it accepts a new request. An endPage of 0 produces the pulse with no flash operation at all.
- R4: After the erase completes, every word 0..WORDS-1 of the page is programmed with opType 2'b01, opAddr = {page, word} and opWords = BEATS. Write beat i carries fillData bits [i*DATA_W +: DATA_W].
- R5: A write beat advances only on wValid and wReady both high. While wReady is low, wValid stays high and wData holds.
- R6: After each program completes, the same word is read back with opType 2'b00 and rReady high. Each beat taken on rValid is compared with the filler beat of the same index. A mismatch sets verifyErr, which stays set until reset.
- R7: fillData is sampled once at the start of each word and held until that word's read-back ends. Changes to fillData during the word affect only later words.
- R8: A high halt seen in idle, page-select or word-select sends the engine to a disabled state that it leaves only by reset: no further operations and no wipeDone. An operation already under way runs to completion first.
- R9: opStart is a one-cycle pulse at the beginning of each operation, and a new operation never starts before the previous one has completed.
- R10: fsmErr stays low throughout legal operation. An undefined state code leads to an absorbing invalid state with fsmErr high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wipeReq | input | 1 | Start a wipe of pages 0..endPage-1 |
| endPage | input | $clog2(PAGES+1) | Exclusive upper page bound |
| fillData | input | BEATS*DATA_W | Filler word, beat i in slice i |
| halt | input | 1 | Permanently disable at the next decision point |
| opStart | output | 1 | Operation start pulse |
| opType | output | 2 | 00 read, 01 program, 10 erase |
| opAddr | output | $clog2(PAGES)+$clog2(WORDS) | {page, word} address |
| opWords | output | $clog2(BEATS+1) | Beats per operation |
| wValid | output | 1 | Write beat valid |
| wData | output | DATA_W | Write beat data |
| wReady | input | 1 | Flash accepts write beat |
| rValid | input | 1 | Read beat valid |
| rData | input | DATA_W | Read beat data |
| rReady | output | 1 | Engine accepts read beats |
| opDone | input | 1 | Current operation complete |
| wipeDone | output | 1 | Range finished pulse |
| verifyErr | output | 1 | Sticky read-back mismatch |
| fsmErr | output | 1 | Invalid state reached |

## Verification
The hardest situation to reach is a halt that lands while a program or read-back burst is in flight. The engine must finish that word and only then park. To get there, the bench watches the flash model's count of program starts and raises halt in the same cycle the first program begins. It then confirms that exactly one program and one read were carried out and that the word holds the filler. A second hard case is a filler change partway through a word. It is driven at the same moment, and the bench expects the first word to hold the old filler and every later word the new one.

// File: rtl/wipe_pkg.sv
`timescale 1ns/1ps
package wipe_pkg;

  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_PAGE_SEL   = 4'd1,
    ST_ERASE      = 4'd2,
    ST_ERASE_WAIT = 4'd3,
    ST_WORD_SEL   = 4'd4,
    ST_PROGRAM    = 4'd5,
    ST_PROG_WAIT  = 4'd6,
    ST_RD_VERIFY  = 4'd7,
    ST_DISABLED   = 4'd8,
    ST_INVALID    = 4'd9
  } wipeState_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } flashOp_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic pageClr;
    logic pageInc;
    logic wordClr;
    logic wordInc;
    logic beatClr;
    logic fillLoad;
    logic progEn;
    logic readEn;
  } wipeStrb_t;

endpackage

// File: rtl/wipe_ctrl.sv
`timescale 1ns/1ps
module wipe_ctrl
  import wipe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wipeReq,
  input  logic       halt,
  input  logic       opDone,
  input  logic       wReady,
  input  logic       pageBelow,
  input  logic       wordBelow,
  input  logic       beatLast,
  output wipeStrb_t  strb,
  output wipeState_e state,
  output logic       opStart,
  output flashOp_e   opType,
  output logic       wValid,
  output logic       rReady,
  output logic       wipeDone,
  output logic       fsmErr
);

  wipeState_e nextState;
  logic       startQ;
  logic       doneQ;

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (halt) nextState = ST_DISABLED;
        else if (wipeReq) begin
          nextState    = ST_PAGE_SEL;
          strb.pageClr = 1'b1;
        end
      end
      ST_PAGE_SEL: begin
        if (halt) nextState = ST_DISABLED;
        else if (pageBelow) nextState = ST_ERASE;
        else nextState = ST_IDLE;
      end
      ST_ERASE: nextState = ST_ERASE_WAIT;
      ST_ERASE_WAIT: begin
        if (opDone) begin
          nextState    = ST_WORD_SEL;
          strb.wordClr = 1'b1;
        end
      end
      ST_WORD_SEL: begin
        if (halt) nextState = ST_DISABLED;
        else if (wordBelow) begin
          nextState     = ST_PROGRAM;
          strb.fillLoad = 1'b1;
          strb.beatClr  = 1'b1;
        end else begin
          nextState    = ST_PAGE_SEL;
          strb.pageInc = 1'b1;
        end
      end
      ST_PROGRAM: begin
        strb.progEn = 1'b1;
        if (beatLast && wReady) nextState = ST_PROG_WAIT;
      end
      ST_PROG_WAIT: begin
        if (opDone) begin
          nextState    = ST_RD_VERIFY;
          strb.beatClr = 1'b1;
        end
      end
      ST_RD_VERIFY: begin
        strb.readEn = 1'b1;
        if (beatLast && opDone) begin
          nextState    = ST_WORD_SEL;
          strb.wordInc = 1'b1;
        end
      end
      ST_DISABLED: nextState = ST_DISABLED;
      default:     nextState = ST_INVALID;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      startQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      state  <= nextState;
      startQ <= (state == ST_WORD_SEL && nextState == ST_PROGRAM) ||
                (state == ST_PROG_WAIT && nextState == ST_RD_VERIFY);
      doneQ  <= (state == ST_PAGE_SEL) && (nextState == ST_IDLE);
    end
  end

  always_comb begin
    case (state)
      ST_ERASE:                 opType = OP_ERASE;
      ST_PROGRAM, ST_PROG_WAIT: opType = OP_PROG;
      default:                  opType = OP_READ;
    endcase
  end

  assign opStart  = (state == ST_ERASE) || startQ;
  assign wValid   = (state == ST_PROGRAM);
  assign rReady   = (state == ST_RD_VERIFY);
  assign wipeDone = doneQ;
  assign fsmErr   = (state == ST_INVALID);

endmodule

// File: rtl/wipe_dpath.sv
`timescale 1ns/1ps
module wipe_dpath
  import wipe_pkg::*;
#(
  parameter int PAGES  = 8,
  parameter int WORDS  = 4,
  parameter int BEATS  = 4,
  parameter int DATA_W = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  wipeStrb_t                          strb,
  input  logic [$clog2(PAGES+1)-1:0]         endPage,
  input  logic [BEATS*DATA_W-1:0]            fillData,
  input  logic                               wReady,
  input  logic                               rValid,
  input  logic [DATA_W-1:0]                  rData,
  output logic                               pageBelow,
  output logic                               wordBelow,
  output logic                               beatLast,
  output logic [$clog2(PAGES)-1:0]           pageIdx,
  output logic [$clog2(WORDS)-1:0]           wordIdx,
  output logic [DATA_W-1:0]                  wData,
  output logic                               verifyErr
);

  localparam int PAGE_W  = $clog2(PAGES+1);
  localparam int PG_AW   = $clog2(PAGES);
  localparam int WCNT_W  = $clog2(WORDS+1);
  localparam int WORD_AW = $clog2(WORDS);
  localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int FILL_W  = BEATS*DATA_W;

  logic [PAGE_W-1:0] pageCnt;
  logic [WCNT_W-1:0] wordCnt;
  logic [BEAT_W-1:0] beatCnt;
  logic [FILL_W-1:0] fillQ;
  logic [DATA_W-1:0] fillBeat [BEATS];
  logic              errQ;
  logic              beatStep;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    assign fillBeat[b] = fillQ[b*DATA_W +: DATA_W];
  end

  assign beatLast  = (beatCnt == BEAT_W'(BEATS-1));
  assign pageBelow = (pageCnt < endPage);
  assign wordBelow = (wordCnt < WCNT_W'(WORDS));
  assign pageIdx   = pageCnt[PG_AW-1:0];
  assign wordIdx   = wordCnt[WORD_AW-1:0];
  assign wData     = fillBeat[beatCnt];
  assign verifyErr = errQ;
  assign beatStep  = (strb.progEn && wReady) || (strb.readEn && rValid);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageCnt <= '0;
      wordCnt <= '0;
      beatCnt <= '0;
      fillQ   <= '0;
      errQ    <= 1'b0;
    end else begin
      if (strb.pageClr)      pageCnt <= '0;
      else if (strb.pageInc) pageCnt <= pageCnt + 1'b1;

      if (strb.wordClr)      wordCnt <= '0;
      else if (strb.wordInc) wordCnt <= wordCnt + 1'b1;

      if (strb.beatClr)      beatCnt <= '0;
      else if (beatStep)     beatCnt <= beatLast ? '0 : beatCnt + 1'b1;

      if (strb.fillLoad)     fillQ <= fillData;

      if (strb.readEn && rValid && (rData != fillBeat[beatCnt])) errQ <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_wipe_engine.sv
`timescale 1ns/1ps
module flash_wipe_engine
  import wipe_pkg::*;
#(
  parameter int PAGES  = 8,
  parameter int WORDS  = 4,
  parameter int BEATS  = 4,
  parameter int DATA_W = 16,
  localparam int PAGE_W  = $clog2(PAGES+1),
  localparam int ADDR_W  = $clog2(PAGES) + $clog2(WORDS),
  localparam int OPW_W   = $clog2(BEATS+1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wipeReq,
  input  logic [PAGE_W-1:0]       endPage,
  input  logic [BEATS*DATA_W-1:0] fillData,
  input  logic                    halt,
  output logic                    opStart,
  output logic [1:0]              opType,
  output logic [ADDR_W-1:0]       opAddr,
  output logic [OPW_W-1:0]        opWords,
  output logic                    wValid,
  output logic [DATA_W-1:0]       wData,
  input  logic                    wReady,
  input  logic                    rValid,
  input  logic [DATA_W-1:0]       rData,
  output logic                    rReady,
  input  logic                    opDone,
  output logic                    wipeDone,
  output logic                    verifyErr,
  output logic                    fsmErr
);

  wipeStrb_t                  strb;
  wipeState_e                 curState;
  flashOp_e                   opKind;
  logic                       pageBelow;
  logic                       wordBelow;
  logic                       beatLast;
  logic [$clog2(PAGES)-1:0]   pageIdx;
  logic [$clog2(WORDS)-1:0]   wordIdx;

  wipe_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wipeReq   (wipeReq),
    .halt      (halt),
    .opDone    (opDone),
    .wReady    (wReady),
    .pageBelow (pageBelow),
    .wordBelow (wordBelow),
    .beatLast  (beatLast),
    .strb      (strb),
    .state     (curState),
    .opStart   (opStart),
    .opType    (opKind),
    .wValid    (wValid),
    .rReady    (rReady),
    .wipeDone  (wipeDone),
    .fsmErr    (fsmErr)
  );

  wipe_dpath #(
    .PAGES  (PAGES),
    .WORDS  (WORDS),
    .BEATS  (BEATS),
    .DATA_W (DATA_W)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .endPage   (endPage),
    .fillData  (fillData),
    .wReady    (wReady),
    .rValid    (rValid),
    .rData     (rData),
    .pageBelow (pageBelow),
    .wordBelow (wordBelow),
    .beatLast  (beatLast),
    .pageIdx   (pageIdx),
    .wordIdx   (wordIdx),
    .wData     (wData),
    .verifyErr (verifyErr)
  );

  assign opType  = opKind;
  assign opAddr  = {pageIdx, (opKind == OP_ERASE) ? '0 : wordIdx};
  assign opWords = OPW_W'(BEATS);

endmodule

// File: rtl/flash_wipe_engine_chk.sv
`timescale 1ns/1ps
module flash_wipe_engine_chk
  import wipe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              opStart,
  input logic              wValid,
  input logic              wReady,
  input logic [DATA_W-1:0] wData,
  input logic              rReady,
  input logic              wipeDone,
  input logic              verifyErr,
  input wipeState_e        state
);

  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    opStart |=> !opStart);

  // R5
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wValid && !wReady) |=> (wValid && $stable(wData)));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    verifyErr |=> verifyErr);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wipeDone |=> !wipeDone);

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DISABLED) |=> (state == ST_DISABLED) && !opStart && !wipeDone);

  // R4
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wValid && rReady));

  // R10
  invalid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INVALID) |=> (state == ST_INVALID));

endmodule

bind flash_wipe_engine flash_wipe_engine_chk #(.DATA_W(DATA_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .opStart   (opStart),
  .wValid    (wValid),
  .wReady    (wReady),
  .wData     (wData),
  .rReady    (rReady),
  .wipeDone  (wipeDone),
  .verifyErr (verifyErr),
  .state     (curState)
);

// File: tb/tb_flash_wipe_engine.sv
`timescale 1ns/1ps
module tb_flash_wipe_engine;

  localparam int PAGES  = 8;
  localparam int WORDS  = 4;
  localparam int BEATS  = 4;
  localparam int DATA_W = 16;
  localparam int PAGE_W = $clog2(PAGES+1);
  localparam int ADDR_W = $clog2(PAGES) + $clog2(WORDS);
  localparam int OPW_W  = $clog2(BEATS+1);
  localparam int MEM_N  = PAGES*WORDS*BEATS;
  localparam int WORD_AW = $clog2(WORDS);

  // vector: {endPage[28:25], seed[24:9], wPat[8:5], rPat[4:1], corrupt[0]}
  localparam int NVEC = 6;
  localparam logic [28:0] VEC [NVEC] = '{
    {4'd1, 16'h1234, 4'b1111, 4'b1111, 1'b0},
    {4'd3, 16'hA0A0, 4'b0101, 4'b0011, 1'b0},
    {4'd8, 16'h0F0F, 4'b1001, 4'b1111, 1'b0},
    {4'd0, 16'h5555, 4'b1111, 4'b1111, 1'b0},
    {4'd5, 16'hC3C3, 4'b0001, 4'b0010, 1'b0},
    {4'd2, 16'h7777, 4'b1111, 4'b0110, 1'b1}
  };

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    wipeReq = 1'b0;
  logic [PAGE_W-1:0]       endPage = '0;
  logic [BEATS*DATA_W-1:0] fillData = '0;
  logic                    halt = 1'b0;
  logic                    opStart;
  logic [1:0]              opType;
  logic [ADDR_W-1:0]       opAddr;
  logic [OPW_W-1:0]        opWords;
  logic                    wValid;
  logic [DATA_W-1:0]       wData;
  logic                    wReady = 1'b0;
  logic                    rValid = 1'b0;
  logic [DATA_W-1:0]       rData = '0;
  logic                    rReady;
  logic                    opDone = 1'b0;
  logic                    wipeDone;
  logic                    verifyErr;
  logic                    fsmErr;

  flash_wipe_engine #(.PAGES(PAGES), .WORDS(WORDS), .BEATS(BEATS), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .wipeReq(wipeReq), .endPage(endPage), .fillData(fillData),
    .halt(halt), .opStart(opStart), .opType(opType), .opAddr(opAddr), .opWords(opWords),
    .wValid(wValid), .wData(wData), .wReady(wReady), .rValid(rValid), .rData(rData),
    .rReady(rReady), .opDone(opDone), .wipeDone(wipeDone), .verifyErr(verifyErr),
    .fsmErr(fsmErr)
  );

  always #2.5 clk = ~clk;

  int nChk = 0;
  int nFail = 0;

  // flash model state
  logic [DATA_W-1:0] mem [MEM_N];
  int mMode = 0;   // 0 idle, 1 erase, 2 prog, 3 prog done, 4 read
  int mBeat, mBase, mCnt, cyc;
  int eraseCnt, progCnt, readCnt, doneCnt;
  int badWords, overlap, stallBad;
  bit prevStart, stallPrev, corruptPending;
  logic [DATA_W-1:0] lastWData;
  logic [3:0] wPat = 4'hF, rPat = 4'hF;

  task automatic check(input string req, input longint act, input longint exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  function automatic logic [BEATS*DATA_W-1:0] fillOf(input logic [15:0] seed);
    logic [BEATS*DATA_W-1:0] f;
    for (int b = 0; b < BEATS; b++) f[b*DATA_W +: DATA_W] = seed + 16'(b) * 16'h0111;
    return f;
  endfunction

  function automatic logic [DATA_W-1:0] preVal(input int i);
    return 16'h5A5A ^ 16'(i);
  endfunction

  task automatic memInit();
    for (int i = 0; i < MEM_N; i++) mem[i] = preVal(i);
  endtask

  task automatic clearStats();
    eraseCnt = 0; progCnt = 0; readCnt = 0; doneCnt = 0;
    badWords = 0; overlap = 0; stallBad = 0;
  endtask

  task automatic modelStep();
    wReady = 1'b0; rValid = 1'b0; opDone = 1'b0;
    if (!rstN) begin
      mMode = 0; prevStart = 0; stallPrev = 0;
      return;
    end
    if (wipeDone) doneCnt++;
    case (mMode)
      1: if (mCnt == 0) begin opDone = 1'b1; mMode = 0; end else mCnt--;
      2: if (wValid) begin
           wReady = wPat[cyc % 4];
           if (stallPrev && wData != lastWData) stallBad++;
           stallPrev = !wReady;
           lastWData = wData;
           if (wReady) begin
             mem[mBase + mBeat] = wData;
             mBeat++;
             if (mBeat == BEATS) mMode = 3;
           end
         end
      3: begin opDone = 1'b1; mMode = 0; stallPrev = 0; end
      4: if (rReady) begin
           rValid = rPat[cyc % 4];
           if (rValid) begin
             rData = mem[mBase + mBeat];
             if (corruptPending && mBeat == 2) begin
               rData = rData ^ 16'h0001;
               corruptPending = 0;
             end
             mBeat++;
             if (mBeat == BEATS) begin opDone = 1'b1; mMode = 0; end
           end
         end
      default: ;
    endcase
    if (opStart) begin
      if (mMode != 0 || prevStart) overlap++;
      if (opWords != OPW_W'(BEATS)) badWords++;
      mBase = int'(opAddr) * BEATS;
      mBeat = 0;
      case (opType)
        2'b10: begin
          eraseCnt++;
          for (int i = 0; i < WORDS*BEATS; i++)
            mem[(int'(opAddr) >> WORD_AW) * WORDS * BEATS + i] = '1;
          mCnt = 2; mMode = 1;
        end
        2'b01: begin progCnt++; mMode = 2; end
        default: begin readCnt++; mMode = 4; end
      endcase
    end
    prevStart = opStart;
    cyc++;
  endtask

  initial forever begin
    @(negedge clk);
    modelStep();
  end

  function automatic bit memOk(input int e, input logic [BEATS*DATA_W-1:0] f);
    for (int p = 0; p < PAGES; p++)
      for (int w = 0; w < WORDS; w++)
        for (int b = 0; b < BEATS; b++) begin
          int i = (p*WORDS + w)*BEATS + b;
          if (p < e) begin
            if (mem[i] != f[b*DATA_W +: DATA_W]) return 0;
          end else if (mem[i] != preVal(i)) return 0;
        end
    return 1;
  endfunction

  task automatic doReset();
    rstN = 1'b0; wipeReq = 1'b0; halt = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic startWipe(input int e, input logic [BEATS*DATA_W-1:0] f);
    @(negedge clk);
    endPage = PAGE_W'(e); fillData = f; wipeReq = 1'b1;
    @(negedge clk);
    wipeReq = 1'b0;
  endtask

  task automatic waitDone(input int limit, output bit got);
    int base = doneCnt;
    got = 0;
    for (int i = 0; i < limit; i++) begin
      @(posedge clk);
      if (doneCnt > base) begin got = 1; break; end
    end
  endtask

  initial begin
    #750000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit got;
    logic [BEATS*DATA_W-1:0] fA, fB;
    memInit(); clearStats();
    doReset();
    // R1 reset state
    check("R1 idle outputs", {opStart, wValid, rReady, wipeDone, verifyErr, fsmErr}, 0);

    // vector table, no reset between entries
    for (int v = 0; v < NVEC; v++) begin
      int e = int'(VEC[v][28:25]);
      logic [BEATS*DATA_W-1:0] f = fillOf(VEC[v][24:9]);
      memInit(); clearStats();
      wPat = VEC[v][8:5]; rPat = VEC[v][4:1]; corruptPending = VEC[v][0];
      startWipe(e, f);
      waitDone(20000, got);
      repeat (4) @(negedge clk);
      check("R3 wipeDone seen", got, 1);
      check("R3 single pulse", doneCnt, 1);
      check("R2 erase count", eraseCnt, e);
      check("R4 program count", progCnt, e*WORDS);
      check("R6 read count", readCnt, e*WORDS);
      check("R4 page contents", memOk(e, f), 1);
      check("R5 stall hold", stallBad, 0);
      check("R9 no overlap", overlap, 0);
      check("R4 opWords", badWords, 0);
      check("R6 verifyErr", verifyErr, VEC[v][0]);
    end
    check("R10 fsmErr low", fsmErr, 0);
    wPat = 4'hF; rPat = 4'hF; corruptPending = 0;

    // R6 sticky until reset, then cleared
    check("R6 sticky after idle", verifyErr, 1);
    doReset();
    check("R1 verifyErr cleared", verifyErr, 0);

    // R8 halt in idle
    memInit(); clearStats();
    halt = 1'b1;
    startWipe(2, fillOf(16'h1111));
    repeat (50) @(negedge clk);
    halt = 1'b0;
    startWipe(2, fillOf(16'h1111));
    repeat (50) @(negedge clk);
    check("R8 no erase after halt", eraseCnt, 0);
    check("R8 no done after halt", doneCnt, 0);

    // R8 halt during a program burst
    doReset(); memInit(); clearStats();
    fA = fillOf(16'h2468);
    startWipe(2, fA);
    for (int i = 0; i < 2000 && progCnt == 0; i++) @(negedge clk);
    halt = 1'b1;
    repeat (200) @(negedge clk);
    check("R8 word finished program", progCnt, 1);
    check("R8 word finished read", readCnt, 1);
    check("R8 stopped after word", eraseCnt, 1);
    check("R8 no done", doneCnt, 0);
    check("R8 word0 filled", {mem[0], mem[1], mem[2], mem[3]},
          {fA[15:0], fA[31:16], fA[47:32], fA[63:48]});
    halt = 1'b0;

    // R7 filler change mid-word
    doReset(); memInit(); clearStats();
    fA = fillOf(16'h1357); fB = fillOf(16'h9BDF);
    startWipe(1, fA);
    for (int i = 0; i < 2000 && progCnt == 0; i++) @(negedge clk);
    fillData = fB;
    waitDone(5000, got);
    repeat (2) @(negedge clk);
    check("R7 done", got, 1);
    check("R7 word0 old filler", {mem[3], mem[2], mem[1], mem[0]}, fA);
    check("R7 word3 new filler", {mem[15], mem[14], mem[13], mem[12]}, fB);
    check("R7 no verify error", verifyErr, 0);
    check("R10 fsmErr low end", fsmErr, 0);

    summary();
    $finish;
  end

endmodule